// File: doc/BRIEF.md
# Register Target with Error Responses

This block is a single-beat AXI4-Lite subordinate. It holds a small bank of read-write registers, a few read-only words, and a reserved stretch of offsets. It also serves as the catch-all target for the rest of a wider address window. Every read and write address is sorted into one of four regions:

| Region | Read response | Write response |
|--------|---------------|----------------|
| read-write | OKAY | OKAY |
| read-only | OKAY | SLVERR |
| reserved | SLVERR | SLVERR |
| outside the map | DECERR | DECERR |

Register contents change only on a clean, successful write. Any errored access leaves every register exactly as it was.

A one-entry exclusive monitor lets a requester perform an atomic read-modify-write on a single read-write register. It uses one extra lock bit per address channel. An exclusive read of a read-write register sets a reservation and returns EXOKAY. A later exclusive write to the same register succeeds, returns EXOKAY and updates the register, provided no other write reached that register in between. Otherwise the exclusive write returns OKAY and the register is not changed, so the requester can see that the attempt failed. Errors are never sticky: the next legal access after any error completes normally.

With default parameters the block decodes these byte offsets:

| Offsets | Region | Contents |
|---------|--------|----------|
| 0x00, 0x04, 0x08, 0x0C | read-write | four registers |
| 0x10 | read-only | fixed identity word |
| 0x14 | read-only | live value of the `hw_status` input |
| 0x18 to 0x3C | reserved | none |
| 0x40 and above | outside the map | none |

Top module: `axil_errslave`

## Requirements
- R1: After reset, `s_bvalid` and `s_rvalid` are low, `s_awready`, `s_wready` and `s_arready` are high, and every read-write register reads as zero.
- R2: A write to a read-write register returns OKAY (2'b00) and updates only the bytes whose `s_wstrb` bit is set (bit n covers data bits 8n+7:8n). A read of that register returns the stored value with OKAY.
- R3: AW and W may be accepted in either order or together. B is raised only after both have been accepted, and `s_bvalid` with its `s_bresp` holds steady until `s_bready` is high.
- R4: An access at or above byte offset 0x40 returns DECERR (2'b11). A read returns data zero, and a write changes no register.
- R5: A write to a read-only word (0x10 or 0x14) returns SLVERR (2'b10) and ignores its data and strobes. A read of 0x10 returns the identity constant and a read of 0x14 returns `hw_status`, both with OKAY.
- R6: Any access to a reserved offset (0x18 to 0x3C) returns SLVERR. A read returns data zero, and a write changes no register.
- R7: An exclusive read (lock bit high) of a read-write register returns EXOKAY (2'b01) and reserves that register. An exclusive write to the reserved register returns EXOKAY, updates it, and clears the reservation. EXOKAY never answers a non-exclusive access.
- R8: An exclusive write with no matching reservation returns OKAY and leaves the register unchanged. An ordinary write to the reserved register clears the reservation.
- R9: After any error response, the next legal access completes with OKAY. `s_rvalid`, `s_rdata` and `s_rresp` hold steady until `s_rready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awexcl | input | 1 | Write is exclusive |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arexcl | input | 1 | Read is exclusive |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| hw_status | input | DATA_W | Value returned by the status word |

## Verification
The assertions check the handshake rules on every cycle:
- B and R stay stable while they are stalled.
- B never appears before both AW and W have been accepted.
- Every read beyond the map is answered with DECERR.
- Errored read data is zero.
- EXOKAY only ever answers an access that carried the lock bit.

Some properties only the directed scenarios can show, because they need values carried across several transactions:
- An errored write leaves the register contents unchanged.
- Byte strobes merge correctly into the stored value.
- The exclusive reservation is set, consumed and cleared in the right order.
- A legal access that follows an error completes cleanly.

// File: rtl/axil_err_pkg.sv
// Shared types for the register target: response codes and address regions.
package axil_err_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        REGION_RW,
        REGION_RO,
        REGION_RSV,
        REGION_NONE
    } region_e;

endpackage

// File: rtl/axil_err_decode.sv
// Address classifier.
// Sorts a byte address into read-write, read-only, reserved or unmapped, and
// gives the word index inside the map. Purely combinational.
// Assumes word-aligned accesses, so the byte-offset bits are ignored.
module axil_err_decode
    import axil_err_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORD_LSB  = 2,
    parameter int MAP_BYTES = 64,
    parameter int NUM_RW    = 4,
    parameter int NUM_RO    = 2,
    parameter int IDX_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam int WW        = ADDR_W - WORD_LSB;
    localparam int MAP_WORDS = MAP_BYTES >> WORD_LSB;
    localparam logic [WW-1:0] LIM_RW  = WW'(NUM_RW);
    localparam logic [WW-1:0] LIM_RO  = WW'(NUM_RW + NUM_RO);
    localparam logic [WW-1:0] LIM_MAP = WW'(MAP_WORDS);

    logic [WW-1:0] word;
    logic          unused_lsb;

    assign word       = addr[ADDR_W-1:WORD_LSB];
    assign unused_lsb = ^addr[WORD_LSB-1:0];
    assign idx        = word[IDX_W-1:0];

    // Region selection by word number.
    always_comb begin
        if (word < LIM_RW)       region = REGION_RW;
        else if (word < LIM_RO)  region = REGION_RO;
        else if (word < LIM_MAP) region = REGION_RSV;
        else                     region = REGION_NONE;
    end
endmodule

// File: rtl/axil_err_regs.sv
// Read-write register bank with per-byte write enables.
// Assumes the caller raises wr_en only for a committed, error-free write
// whose index lies inside the bank.
module axil_err_regs #(
    parameter int DATA_W = 32,
    parameter int NUM_RW = 4,
    parameter int IDX_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [DATA_W/8-1:0]            wr_strb,
    output logic [NUM_RW-1:0][DATA_W-1:0]  regs_q
);
    localparam int STRB_W = DATA_W / 8;

    for (genvar r = 0; r < NUM_RW; r++) begin : g_reg
        for (genvar b = 0; b < STRB_W; b++) begin : g_byte
            // One byte lane of one register: loads when selected and strobed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[r][b*8 +: 8] <= '0;
                else if (wr_en && wr_idx == IDX_W'(r) && wr_strb[b])
                    regs_q[r][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/axil_err_excl.sv
// One-entry exclusive reservation monitor.
// Set by an exclusive read of a read-write register. Cleared by any committed
// write to the reserved register (ordinary, or successful exclusive).
// A new set wins over a clear that falls in the same cycle.
module axil_err_excl #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             wr_seen,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             hit
);
    logic             resv_v;
    logic [IDX_W-1:0] resv_idx;

    assign hit = resv_v && (resv_idx == wr_idx);

    // Reservation state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_v   <= 1'b0;
            resv_idx <= '0;
        end else if (set_en) begin
            resv_v   <= 1'b1;
            resv_idx <= set_idx;
        end else if (wr_seen && hit) begin
            resv_v   <= 1'b0;
        end
    end
endmodule

// File: rtl/axil_err_wrch.sv
// Write channel joiner.
// Accepts AW and W independently, holds each until both are present, then
// issues one commit pulse and raises B with the response supplied by the
// caller for that commit. No new address or data is accepted while B is
// pending, so at most one write is in flight.
module axil_err_wrch
    import axil_err_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awvalid,
    output logic                awready,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awexcl,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic                bvalid,
    input  logic                bready,
    output logic [1:0]          bresp,
    output logic                cmt_valid,
    output logic [ADDR_W-1:0]   cmt_addr,
    output logic                cmt_excl,
    output logic [DATA_W-1:0]   cmt_data,
    output logic [DATA_W/8-1:0] cmt_strb,
    input  resp_e               cmt_resp
);
    logic aw_q;
    logic w_q;

    assign awready   = !aw_q && !bvalid;
    assign wready    = !w_q && !bvalid;
    assign cmt_valid = aw_q && w_q && !bvalid;

    // Capture address and data, commit when both are held, retire B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_q     <= 1'b0;
            w_q      <= 1'b0;
            cmt_addr <= '0;
            cmt_excl <= 1'b0;
            cmt_data <= '0;
            cmt_strb <= '0;
            bvalid   <= 1'b0;
            bresp    <= RESP_OKAY;
        end else begin
            if (awvalid && awready) begin
                aw_q     <= 1'b1;
                cmt_addr <= awaddr;
                cmt_excl <= awexcl;
            end
            if (wvalid && wready) begin
                w_q      <= 1'b1;
                cmt_data <= wdata;
                cmt_strb <= wstrb;
            end
            if (cmt_valid) begin
                aw_q   <= 1'b0;
                w_q    <= 1'b0;
                bvalid <= 1'b1;
                bresp  <= cmt_resp;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/axil_errslave.sv
// Register target with error responses (top).
// Single-beat AXI4-Lite subordinate with a read-write bank, read-only words,
// reserved offsets and a DECERR default region, plus a one-entry exclusive
// monitor. The first read-only word is a fixed identity value; the others
// return hw_status. Assumes one outstanding read and one outstanding write.
module axil_errslave
    import axil_err_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               DATA_W    = 32,
    parameter int               MAP_BYTES = 64,
    parameter int               NUM_RW    = 4,
    parameter int               NUM_RO    = 2,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h5A17_0001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awexcl,
    input  logic                s_wvalid,
    output logic                s_wready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [1:0]          s_bresp,
    input  logic                s_arvalid,
    output logic                s_arready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arexcl,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    input  logic [DATA_W-1:0]   hw_status
);
    localparam int STRB_W   = DATA_W / 8;
    localparam int WORD_LSB = $clog2(STRB_W);
    localparam int IDX_W    = $clog2(MAP_BYTES >> WORD_LSB);

    // Write side wiring.
    logic                        cmt_valid;
    logic [ADDR_W-1:0]           cmt_addr;
    logic                        cmt_excl;
    logic [DATA_W-1:0]           cmt_data;
    logic [STRB_W-1:0]           cmt_strb;
    resp_e                       cmt_resp;
    region_e                     wr_region;
    logic [IDX_W-1:0]            wr_idx;
    logic                        wr_en;
    logic                        wr_rw;
    logic                        excl_hit;
    logic [NUM_RW-1:0][DATA_W-1:0] regs_q;

    // Read side wiring.
    region_e                     rd_region;
    logic [IDX_W-1:0]            rd_idx;
    logic                        ar_hs;
    logic                        excl_set;
    logic [DATA_W-1:0]           rd_data_c;
    resp_e                       rd_resp_c;

    axil_err_wrch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wrch (
        .clk      (clk),
        .rst_n    (rst_n),
        .awvalid  (s_awvalid),
        .awready  (s_awready),
        .awaddr   (s_awaddr),
        .awexcl   (s_awexcl),
        .wvalid   (s_wvalid),
        .wready   (s_wready),
        .wdata    (s_wdata),
        .wstrb    (s_wstrb),
        .bvalid   (s_bvalid),
        .bready   (s_bready),
        .bresp    (s_bresp),
        .cmt_valid(cmt_valid),
        .cmt_addr (cmt_addr),
        .cmt_excl (cmt_excl),
        .cmt_data (cmt_data),
        .cmt_strb (cmt_strb),
        .cmt_resp (cmt_resp)
    );

    axil_err_decode #(
        .ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB), .MAP_BYTES(MAP_BYTES),
        .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .IDX_W(IDX_W)
    ) u_wr_dec (
        .addr  (cmt_addr),
        .region(wr_region),
        .idx   (wr_idx)
    );

    axil_err_decode #(
        .ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB), .MAP_BYTES(MAP_BYTES),
        .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .IDX_W(IDX_W)
    ) u_rd_dec (
        .addr  (s_araddr),
        .region(rd_region),
        .idx   (rd_idx)
    );

    axil_err_excl #(.IDX_W(IDX_W)) u_excl (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (excl_set),
        .set_idx(rd_idx),
        .wr_seen(wr_rw),
        .wr_idx (wr_idx),
        .hit    (excl_hit)
    );

    axil_err_regs #(.DATA_W(DATA_W), .NUM_RW(NUM_RW), .IDX_W(IDX_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(cmt_data),
        .wr_strb(cmt_strb),
        .regs_q (regs_q)
    );

    assign wr_rw = cmt_valid && (wr_region == REGION_RW);

    // Write response: region error first, then the exclusive outcome.
    always_comb begin
        wr_en    = 1'b0;
        cmt_resp = RESP_OKAY;
        case (wr_region)
            REGION_NONE: cmt_resp = RESP_DECERR;
            REGION_RO,
            REGION_RSV:  cmt_resp = RESP_SLVERR;
            default: begin
                if (cmt_excl) begin
                    cmt_resp = excl_hit ? RESP_EXOKAY : RESP_OKAY;
                    wr_en    = cmt_valid && excl_hit;
                end else begin
                    wr_en    = cmt_valid;
                end
            end
        endcase
    end

    assign s_arready = !s_rvalid;
    assign ar_hs     = s_arvalid && s_arready;
    assign excl_set  = ar_hs && s_arexcl && (rd_region == REGION_RW);

    // Read data and response for the address currently presented.
    always_comb begin
        rd_data_c = '0;
        rd_resp_c = RESP_OKAY;
        case (rd_region)
            REGION_NONE: rd_resp_c = RESP_DECERR;
            REGION_RSV:  rd_resp_c = RESP_SLVERR;
            REGION_RO:   rd_data_c = (rd_idx == IDX_W'(NUM_RW)) ? ID_VALUE : hw_status;
            default: begin
                for (int i = 0; i < NUM_RW; i++)
                    if (rd_idx == IDX_W'(i)) rd_data_c = regs_q[i];
                rd_resp_c = s_arexcl ? RESP_EXOKAY : RESP_OKAY;
            end
        endcase
    end

    // Read response register: load on address accept, hold until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
            s_rresp  <= RESP_OKAY;
        end else if (ar_hs) begin
            s_rvalid <= 1'b1;
            s_rdata  <= rd_data_c;
            s_rresp  <= rd_resp_c;
        end else if (s_rvalid && s_rready) begin
            s_rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/axil_err_chk.sv
// Protocol checker for the register target, attached by bind.
// Keeps its own record of accepted AW/W and of the last read address, and
// checks response timing and coding against it.
module axil_err_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MAP_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic              s_awexcl,
    input logic              s_wvalid,
    input logic              s_wready,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [1:0]        s_bresp,
    input logic              s_arvalid,
    input logic              s_arready,
    input logic [ADDR_W-1:0] s_araddr,
    input logic              s_arexcl,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [1:0]        s_rresp,
    input logic [DATA_W-1:0] s_rdata
);
    logic aw_seen, w_seen, aw_lock_seen;

    // Record accepted write halves until their response is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_seen      <= 1'b0;
            w_seen       <= 1'b0;
            aw_lock_seen <= 1'b0;
        end else if (s_bvalid && s_bready) begin
            aw_seen <= 1'b0;
            w_seen  <= 1'b0;
        end else begin
            if (s_awvalid && s_awready) begin
                aw_seen      <= 1'b1;
                aw_lock_seen <= s_awexcl;
            end
            if (s_wvalid && s_wready) w_seen <= 1'b1;
        end
    end

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp)); // R3
    AST_B_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> aw_seen && w_seen); // R3
    AST_RD_DECERR: assert property (@(posedge clk) disable iff (!rst_n)
        s_arvalid && s_arready && (s_araddr >= ADDR_W'(MAP_BYTES)) |=> s_rvalid && s_rresp == 2'b11); // R4
    AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && s_rresp[1] |-> s_rdata == '0); // R6
    AST_RD_EXOKAY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        s_arvalid && s_arready && !s_arexcl |=> s_rresp != 2'b01); // R7
    AST_WR_EXOKAY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && s_bresp == 2'b01 |-> aw_lock_seen); // R7
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rresp) && $stable(s_rdata)); // R9
endmodule

bind axil_errslave axil_err_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAP_BYTES(MAP_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_awvalid(s_awvalid),
    .s_awready(s_awready),
    .s_awexcl (s_awexcl),
    .s_wvalid (s_wvalid),
    .s_wready (s_wready),
    .s_bvalid (s_bvalid),
    .s_bready (s_bready),
    .s_bresp  (s_bresp),
    .s_arvalid(s_arvalid),
    .s_arready(s_arready),
    .s_araddr (s_araddr),
    .s_arexcl (s_arexcl),
    .s_rvalid (s_rvalid),
    .s_rready (s_rready),
    .s_rresp  (s_rresp),
    .s_rdata  (s_rdata)
);

// File: tb/axil_errslave_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module axil_errslave_tb;
    localparam logic [1:0] OKAY = 2'b00, EXOK = 2'b01, SLVE = 2'b10, DECE = 2'b11;
    localparam logic [31:0] ID_VAL = 32'h5A17_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_awvalid = 0, s_awexcl = 0, s_wvalid = 0, s_bready = 0;
    logic        s_arvalid = 0, s_arexcl = 0, s_rready = 0;
    logic [15:0] s_awaddr = '0, s_araddr = '0;
    logic [31:0] s_wdata = '0, hw_status = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    axil_errslave u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awexcl(s_awexcl),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arexcl(s_arexcl),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .hw_status(hw_status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Write: ord 0 = AW and W together, 1 = AW first, 2 = W first.
    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] st,
                            input bit ex, input int ord, input int hold, output logic [1:0] r);
        bit aw_done = 0, w_done = 0, hs_aw, hs_w;
        int guard = 0;
        @(negedge clk);
        if (ord != 2) begin s_awaddr = a; s_awexcl = ex; s_awvalid = 1; end
        if (ord != 1) begin s_wdata = d; s_wstrb = st; s_wvalid = 1; end
        while (!(aw_done && w_done) && guard < 50) begin
            hs_aw = s_awvalid && s_awready;
            hs_w  = s_wvalid && s_wready;
            @(negedge clk);
            guard++;
            if (hs_aw) begin s_awvalid = 0; s_awexcl = 0; aw_done = 1; end
            if (hs_w)  begin s_wvalid = 0; w_done = 1; end
            if (!(aw_done && w_done) && (aw_done || w_done)) begin
                repeat (2) begin
                    @(negedge clk);
                    check(!s_bvalid, "R3", "B raised with one half missing", 32'(s_bvalid), 0);
                end
                if (!w_done && !s_wvalid) begin s_wdata = d; s_wstrb = st; s_wvalid = 1; end
                if (!aw_done && !s_awvalid) begin s_awaddr = a; s_awexcl = ex; s_awvalid = 1; end
            end
        end
        guard = 0;
        while (!s_bvalid && guard < 50) begin @(negedge clk); guard++; end
        r = s_bresp;
        repeat (hold) begin
            @(negedge clk);
            check(s_bvalid && s_bresp == r, "R3", "B not held", {30'b0, s_bresp}, {30'b0, r});
        end
        s_bready = 1;
        @(negedge clk);
        s_bready = 0;
    endtask

    task automatic do_read(input logic [15:0] a, input bit ex, input int hold,
                           output logic [31:0] d, output logic [1:0] r);
        int guard = 0;
        @(negedge clk);
        s_araddr = a; s_arexcl = ex; s_arvalid = 1;
        while (!s_arready && guard < 50) begin @(negedge clk); guard++; end
        @(negedge clk);
        s_arvalid = 0; s_arexcl = 0;
        guard = 0;
        while (!s_rvalid && guard < 50) begin @(negedge clk); guard++; end
        d = s_rdata; r = s_rresp;
        repeat (hold) begin
            @(negedge clk);
            check(s_rvalid && s_rdata == d && s_rresp == r, "R9", "R not held", s_rdata, d);
        end
        s_rready = 1;
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] r;
        check(!s_bvalid && !s_rvalid, "R1", "valid after reset", {s_bvalid, s_rvalid}, 0);
        check(s_awready && s_wready && s_arready, "R1", "ready after reset",
              {s_awready, s_wready, s_arready}, 3'b111);
        for (int i = 0; i < 4; i++) begin
            do_read(16'(i * 4), 0, 0, d, r);
            check(d == 0 && r == OKAY, "R1", "register reset value", d, 0);
        end
    endtask

    task automatic t_rw();
        logic [31:0] d; logic [1:0] r;
        do_write(16'h0004, 32'h1122_3344, 4'hF, 0, 0, 0, r);
        check(r == OKAY, "R2", "full write resp", r, OKAY);
        do_read(16'h0004, 0, 0, d, r);
        check(d == 32'h1122_3344 && r == OKAY, "R2", "full write readback", d, 32'h1122_3344);
        do_write(16'h0004, 32'hAABB_CCDD, 4'b0101, 0, 0, 0, r);
        do_read(16'h0004, 0, 0, d, r);
        check(d == 32'h11BB_33DD, "R2", "strobed merge", d, 32'h11BB_33DD);
    endtask

    task automatic t_order();
        logic [31:0] d; logic [1:0] r;
        do_write(16'h0008, 32'hCAFE_0001, 4'hF, 0, 1, 3, r);
        check(r == OKAY, "R3", "AW-first resp", r, OKAY);
        do_read(16'h0008, 0, 0, d, r);
        check(d == 32'hCAFE_0001, "R3", "AW-first data", d, 32'hCAFE_0001);
        do_write(16'h0008, 32'hCAFE_0002, 4'hF, 0, 2, 2, r);
        do_read(16'h0008, 0, 0, d, r);
        check(d == 32'hCAFE_0002, "R3", "W-first data", d, 32'hCAFE_0002);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic [1:0] r;
        do_write(16'h0000, 32'h0102_0304, 4'hF, 0, 0, 0, r);
        do_write(16'h0040, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, r);
        check(r == DECERR_c(), "R4", "unmapped write resp", r, DECE);
        do_read(16'h0000, 0, 0, d, r);
        check(d == 32'h0102_0304, "R4", "unmapped write altered reg", d, 32'h0102_0304);
        do_read(16'h0100, 0, 0, d, r);
        check(r == DECE && d == 0, "R4", "unmapped read", {d[29:0], r}, {30'b0, DECE});
        do_read(16'hFFFC, 0, 0, d, r);
        check(r == DECE, "R4", "top-of-window read", r, DECE);
    endtask

    function automatic logic [1:0] DECERR_c();
        return DECE;
    endfunction

    task automatic t_ro();
        logic [31:0] d; logic [1:0] r;
        do_write(16'h0010, 32'hDEAD_BEEF, 4'hF, 0, 0, 0, r);
        check(r == SLVE, "R5", "identity write resp", r, SLVE);
        do_read(16'h0010, 0, 0, d, r);
        check(d == ID_VAL && r == OKAY, "R5", "identity read", d, ID_VAL);
        hw_status = 32'h0BAD_F00D;
        do_write(16'h0014, 32'h1234_5678, 4'hF, 0, 1, 0, r);
        check(r == SLVE, "R5", "status write resp", r, SLVE);
        do_read(16'h0014, 0, 0, d, r);
        check(d == 32'h0BAD_F00D && r == OKAY, "R5", "status read", d, 32'h0BAD_F00D);
    endtask

    task automatic t_reserved();
        logic [31:0] d; logic [1:0] r;
        do_read(16'h0020, 0, 0, d, r);
        check(r == SLVE && d == 0, "R6", "reserved read", d, 0);
        do_write(16'h003C, 32'h7777_7777, 4'hF, 0, 0, 0, r);
        check(r == SLVE, "R6", "reserved write resp", r, SLVE);
        do_read(16'h000C, 0, 0, d, r);
        check(d == 0, "R6", "reserved write altered reg", d, 0);
    endtask

    task automatic t_excl_ok();
        logic [31:0] d; logic [1:0] r;
        do_read(16'h000C, 1, 0, d, r);
        check(r == EXOK, "R7", "exclusive read resp", r, EXOK);
        do_write(16'h000C, 32'h0000_0077, 4'hF, 1, 0, 0, r);
        check(r == EXOK, "R7", "exclusive write resp", r, EXOK);
        do_read(16'h000C, 0, 0, d, r);
        check(d == 32'h77 && r == OKAY, "R7", "exclusive write data", d, 32'h77);
        do_write(16'h000C, 32'h0000_0088, 4'hF, 1, 0, 0, r);
        check(r == OKAY, "R8", "reuse of consumed reservation", r, OKAY);
        do_read(16'h000C, 0, 0, d, r);
        check(d == 32'h77, "R8", "failed exclusive altered reg", d, 32'h77);
    endtask

    task automatic t_excl_fail();
        logic [31:0] d; logic [1:0] r;
        do_read(16'h000C, 1, 0, d, r);
        do_write(16'h000C, 32'h0000_0099, 4'hF, 0, 0, 0, r);
        check(r == OKAY, "R8", "ordinary write resp", r, OKAY);
        do_write(16'h000C, 32'h0000_00AA, 4'hF, 1, 0, 0, r);
        check(r == OKAY, "R8", "exclusive after clear resp", r, OKAY);
        do_read(16'h000C, 0, 0, d, r);
        check(d == 32'h99, "R8", "exclusive after clear data", d, 32'h99);
    endtask

    task automatic t_recovery();
        logic [31:0] d; logic [1:0] r;
        do_write(16'h0200, 32'h1, 4'hF, 0, 0, 0, r);
        do_write(16'h0000, 32'h0000_0055, 4'hF, 0, 0, 0, r);
        check(r == OKAY, "R9", "write after DECERR", r, OKAY);
        do_read(16'h0030, 0, 0, d, r);
        check(r == SLVE, "R9", "reserved read before recovery", r, SLVE);
        do_read(16'h0000, 0, 3, d, r);
        check(r == OKAY && d == 32'h55, "R9", "read after SLVERR", d, 32'h55);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_order();
        t_unmapped();
        t_ro();
        t_reserved();
        t_excl_ok();
        t_excl_fail();
        t_recovery();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule